// File: doc/BRIEF.md
# Doorbell Mailbox Register Controller

This block is the local-side endpoint of a doorbell mailbox. A local processor and a remote host use it to signal each other. It has three 32-bit registers on a simple request/response register bus. The status register collects doorbells rung by the host; the processor acknowledges them by writing 1 to clear. The control register holds one interrupt enable per channel. The command register carries doorbells from the processor to the host; the processor writes 1 to set bits, and the host acknowledges them through its own clear vector. One registered, level-sensitive interrupt goes to the processor. A second address space holds a small shared data RAM of parameterized depth.

Every request is accepted in the cycle it is presented. A small access state machine handles each request. Its states are `ACC_IDLE` (no read response pending), `ACC_REG_RD` (a register read response is being returned), `ACC_RAM_RD` (a RAM read response is being returned) and `ACC_NULL_RD` (a read of an invalid address returns zero). On every clock edge the machine moves to one of four states. It goes to `ACC_REG_RD` for a valid register read, to `ACC_RAM_RD` for a valid RAM read, and to `ACC_NULL_RD` for a misaligned or unmapped read. For a write or for no request, it goes to `ACC_IDLE`. Any state can move to any other on the next edge, so back-to-back reads run at full rate.

Top module: `doorbell_mbox_ctrl`

## Requirements
- R1: While reset is asserted, and right after it, all three registers read 0 and `irq`, `host_cmd` and `rsp_valid` are 0.
- R2: A write to the control register (byte offset 0x4) replaces its whole 32-bit value. The control register does not change in any cycle without such a write.
- R3: A write to the command register (offset 0x8) sets every bit that is 1 in the data, and a local write never clears a bit. A 1 in `host_clr` clears that command bit. If a local set and a host clear hit the same bit in the same cycle, the bit ends up 1.
- R4: A write to the status register (offset 0x0) clears every bit that is 1 in the data and leaves the other bits unchanged. A 1 in `host_set[i]` sets status bit i. A host set beats a local clear of the same bit in the same cycle.
- R5: `irq` is a register. After each clock edge it equals the OR of bits 7:0 of (status AND control), using the register values produced by that same edge.
- R6: A valid register read raises `rsp_valid` for one cycle, one clock after the request. `rsp_data[15:0]` then holds the low 16 bits of the register value from before that edge, and `rsp_data[31:16]` is 0.
- R7: A request is valid only if `req_addr[1:0]` is 0. A register-space read of a misaligned address or of an offset of 0xC or above returns 0 with `rsp_valid` high. A write to such an address changes no register.
- R8: With `req_space`=1, word `req_addr>>2` of the RAM is written with all 32 bits, or read back with one cycle of latency. A read beyond the RAM depth returns 0, and a write beyond it changes no word.
- R9: `host_cmd` always shows the current command register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_space | input | 1 | 0 = register space, 1 = shared RAM |
| req_addr | input | ADDR_W (12) | Byte address within the space |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read response valid |
| rsp_data | output | 32 | Read response data |
| host_set | input | CHAN (8) | Host doorbell set vector into status bits |
| host_clr | input | 32 | Host acknowledge, clears command bits |
| host_cmd | output | 32 | Command register toward the host |
| irq | output | 1 | Level interrupt to the local processor |

## Verification
The bench targets same-cycle conflicts: a host set against a local status clear, and a host clear against a local command set. A design that resolved either the other way would lose a doorbell. It checks `irq` in the cycle right after an enabling write or a host set. An interrupt built from old register values would show up one cycle late, and a combinational one would show up early. It also checks misaligned writes, unmapped offsets and RAM addresses past the end. A decoder that ignored the low address bits would corrupt a live register or wrap into the RAM. Reads of values with non-zero upper halves catch a design that does not truncate to 16 bits.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
    localparam int DATA_W  = 32;
    localparam int CHAN    = 8;
    localparam int VIS_W   = 16;
    localparam int NUM_REG = 3;

    typedef enum logic [1:0] {
        ACC_IDLE    = 2'd0,
        ACC_REG_RD  = 2'd1,
        ACC_RAM_RD  = 2'd2,
        ACC_NULL_RD = 2'd3
    } acc_state_e;

    // Word index of each register; the decoder relies on this order.
    typedef enum logic [1:0] {
        SEL_STAT = 2'd0,
        SEL_CTRL = 2'd1,
        SEL_CMD  = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/mbx_access_fsm.sv
module mbx_access_fsm
    import mbx_pkg::*;
#(
    parameter int ADDR_W    = 12,
    parameter int RAM_WORDS = 64,
    localparam int WIDX_W   = ADDR_W - 2,
    localparam int RIDX_W   = $clog2(RAM_WORDS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic                req_write,
    input  logic                req_space,
    input  logic [ADDR_W-1:0]   req_addr,
    output logic                reg_wr_en,
    output logic                reg_rd_en,
    output reg_sel_e            reg_sel,
    output logic                ram_wr_en,
    output logic                ram_rd_en,
    output logic [RIDX_W-1:0]   ram_idx,
    input  logic [DATA_W-1:0]   reg_rd_data,
    input  logic [DATA_W-1:0]   ram_rd_data,
    output logic                rsp_valid,
    output logic [DATA_W-1:0]   rsp_data
);
    localparam logic [WIDX_W-1:0] REG_LIM = WIDX_W'(NUM_REG);
    localparam logic [WIDX_W-1:0] RAM_LIM = WIDX_W'(RAM_WORDS);

    acc_state_e          state_q, state_d;
    logic                aligned, reg_hit, ram_hit, is_read;
    logic [WIDX_W-1:0]   widx;

    // Address decode
    always_comb begin
        aligned   = (req_addr[1:0] == 2'b00);
        widx      = req_addr[ADDR_W-1:2];
        reg_hit   = aligned && (widx < REG_LIM);
        ram_hit   = aligned && (widx < RAM_LIM);
        is_read   = req_valid && !req_write;
        reg_sel   = reg_hit ? reg_sel_e'(widx[1:0]) : SEL_NONE;
        ram_idx   = widx[RIDX_W-1:0];
        reg_wr_en = req_valid && req_write && !req_space && reg_hit;
        reg_rd_en = is_read && !req_space && reg_hit;
        ram_wr_en = req_valid && req_write && req_space && ram_hit;
        ram_rd_en = is_read && req_space && ram_hit;
    end

    // Next-state selection
    always_comb begin
        state_d = ACC_IDLE;
        if (is_read) begin
            if (req_space) state_d = ram_hit ? ACC_RAM_RD : ACC_NULL_RD;
            else           state_d = reg_hit ? ACC_REG_RD : ACC_NULL_RD;
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ACC_IDLE;
        else        state_q <= state_d;
    end

    // Outputs per state
    always_comb begin
        rsp_valid = 1'b0;
        rsp_data  = '0;
        unique case (state_q)
            ACC_IDLE:    begin rsp_valid = 1'b0; rsp_data = '0;          end
            ACC_REG_RD:  begin rsp_valid = 1'b1; rsp_data = reg_rd_data; end
            ACC_RAM_RD:  begin rsp_valid = 1'b1; rsp_data = ram_rd_data; end
            ACC_NULL_RD: begin rsp_valid = 1'b1; rsp_data = '0;          end
        endcase
    end

    AST_RSP_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(req_valid && !req_write)); // R6
    AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ACC_REG_RD) |-> (rsp_data[DATA_W-1:VIS_W] == '0)); // R6
    AST_BAD_ADDR_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_addr[1:0] != 2'b00) |-> !(reg_wr_en || ram_wr_en)); // R7
endmodule

// File: rtl/mbx_regfile.sv
module mbx_regfile
    import mbx_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic                rd_en,
    input  reg_sel_e            sel,
    input  logic [DATA_W-1:0]   wdata,
    input  logic [CHAN-1:0]     host_set,
    input  logic [DATA_W-1:0]   host_clr,
    output logic [DATA_W-1:0]   rd_data,
    output logic [DATA_W-1:0]   cmd_q,
    output logic                irq
);
    logic [DATA_W-1:0] status_q, ctrl_q;
    logic [DATA_W-1:0] status_d, ctrl_d, cmd_d;
    logic [DATA_W-1:0] clr_mask, set_mask, rd_mux;

    always_comb begin
        clr_mask = (wr_en && sel == SEL_STAT) ? wdata : '0;
        set_mask = (wr_en && sel == SEL_CMD)  ? wdata : '0;
        // Host set is applied after the local clear, so it wins.
        status_d = (status_q & ~clr_mask) | {{(DATA_W-CHAN){1'b0}}, host_set};
        ctrl_d   = (wr_en && sel == SEL_CTRL) ? wdata : ctrl_q;
        // Local set is applied after the host clear, so it wins.
        cmd_d    = (cmd_q & ~host_clr) | set_mask;
    end

    always_comb begin
        case (sel)
            SEL_STAT: rd_mux = status_q;
            SEL_CTRL: rd_mux = ctrl_q;
            SEL_CMD:  rd_mux = cmd_q;
            default:  rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            status_q <= '0;
            ctrl_q   <= '0;
            cmd_q    <= '0;
            irq      <= 1'b0;
            rd_data  <= '0;
        end else begin
            status_q <= status_d;
            ctrl_q   <= ctrl_d;
            cmd_q    <= cmd_d;
            irq      <= |(status_d[CHAN-1:0] & ctrl_d[CHAN-1:0]);
            if (rd_en) rd_data <= {{(DATA_W-VIS_W){1'b0}}, rd_mux[VIS_W-1:0]};
        end
    end

    AST_IRQ_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
        irq == |(status_q[CHAN-1:0] & ctrl_q[CHAN-1:0])); // R5
    AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && sel == SEL_CTRL) |=> $stable(ctrl_q)); // R2
    AST_CMD_NO_LOCAL_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (host_clr == '0) |=> ((cmd_q & $past(cmd_q)) == $past(cmd_q))); // R3
    AST_HOST_SET_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        (host_set != '0) |=> ((status_q[CHAN-1:0] & $past(host_set)) == $past(host_set))); // R4
    AST_STAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!(wr_en && sel == SEL_STAT) && host_set == '0) |=> $stable(status_q)); // R4
endmodule

// File: rtl/mbx_ram.sv
module mbx_ram
    import mbx_pkg::*;
#(
    parameter int WORDS    = 64,
    localparam int IDX_W   = $clog2(WORDS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic               rd_en,
    input  logic [IDX_W-1:0]   idx,
    input  logic [DATA_W-1:0]  wdata,
    output logic [DATA_W-1:0]  rd_data
);
    logic [DATA_W-1:0] mem [WORDS];

    always_ff @(posedge clk) begin
        if (wr_en) mem[idx] <= wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     rd_data <= '0;
        else if (rd_en) rd_data <= mem[idx];
    end

    AST_RAM_ONE_OP: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && rd_en)); // R8
endmodule

// File: rtl/doorbell_mbox_ctrl.sv
module doorbell_mbox_ctrl
    import mbx_pkg::*;
#(
    parameter int ADDR_W    = 12,
    parameter int RAM_WORDS = 64,
    localparam int RIDX_W   = $clog2(RAM_WORDS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic               req_write,
    input  logic               req_space,
    input  logic [ADDR_W-1:0]  req_addr,
    input  logic [31:0]        req_wdata,
    output logic               rsp_valid,
    output logic [31:0]        rsp_data,
    input  logic [7:0]         host_set,
    input  logic [31:0]        host_clr,
    output logic [31:0]        host_cmd,
    output logic               irq
);
    logic              reg_wr_en, reg_rd_en, ram_wr_en, ram_rd_en;
    reg_sel_e          reg_sel;
    logic [RIDX_W-1:0] ram_idx;
    logic [31:0]       reg_rd_data, ram_rd_data;

    mbx_access_fsm #(.ADDR_W(ADDR_W), .RAM_WORDS(RAM_WORDS)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_write(req_write),
        .req_space(req_space), .req_addr(req_addr),
        .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en), .reg_sel(reg_sel),
        .ram_wr_en(ram_wr_en), .ram_rd_en(ram_rd_en), .ram_idx(ram_idx),
        .reg_rd_data(reg_rd_data), .ram_rd_data(ram_rd_data),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data)
    );

    mbx_regfile u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_en(reg_wr_en), .rd_en(reg_rd_en), .sel(reg_sel),
        .wdata(req_wdata), .host_set(host_set), .host_clr(host_clr),
        .rd_data(reg_rd_data), .cmd_q(host_cmd), .irq(irq)
    );

    mbx_ram #(.WORDS(RAM_WORDS)) u_ram (
        .clk(clk), .rst_n(rst_n),
        .wr_en(ram_wr_en), .rd_en(ram_rd_en), .idx(ram_idx),
        .wdata(req_wdata), .rd_data(ram_rd_data)
    );

    AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!irq && host_cmd == '0)); // R1
endmodule

// File: tb/tb_doorbell_mbox_ctrl.sv
module tb_doorbell_mbox_ctrl;
    localparam int AW = 12;
    localparam int RW = 64;

    logic clk = 0, rst_n = 0;
    logic req_valid = 0, req_write = 0, req_space = 0;
    logic [AW-1:0] req_addr = '0;
    logic [31:0] req_wdata = '0, host_clr = '0;
    logic [7:0]  host_set = '0;
    logic rsp_valid, irq;
    logic [31:0] rsp_data, host_cmd;

    int n_checks = 0, n_fail = 0;
    logic [31:0] m_stat = 0, m_ctrl = 0, m_cmd = 0;
    logic [31:0] m_mem [RW];

    doorbell_mbox_ctrl #(.ADDR_W(AW), .RAM_WORDS(RW)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_space(req_space), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data), .host_set(host_set),
        .host_clr(host_clr), .host_cmd(host_cmd), .irq(irq)
    );

    always #10 clk = ~clk;

    task automatic check(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] model_reg(input logic [9:0] wi);
        case (wi)
            10'd0:   return m_stat;
            10'd1:   return m_ctrl;
            10'd2:   return m_cmd;
            default: return 32'h0;
        endcase
    endfunction

    // One bus cycle: drive, advance model, sample after the edge.
    task automatic step(input logic v, input logic w, input logic s, input logic [AW-1:0] a,
                        input logic [31:0] d, input logic [7:0] hs, input logic [31:0] hc);
        logic al, ev, inrng;
        logic [9:0] wi;
        logic [31:0] er, wset, wclr;
        string tag;
        req_valid = v; req_write = w; req_space = s; req_addr = a;
        req_wdata = d; host_set = hs; host_clr = hc;
        al = (a[1:0] == 2'b00);
        wi = a[AW-1:2];
        ev = v && !w;
        er = 32'h0;
        tag = "R7";
        inrng = s ? (wi < RW) : (wi < 3);
        if (ev && al && inrng) begin
            if (s) begin er = m_mem[wi[5:0]]; tag = "R8"; end
            else begin
                er = {16'h0, model_reg(wi) & 32'hFFFF};
                tag = (wi == 0) ? "R4" : (wi == 1) ? "R2" : "R3";
            end
        end else if (ev && s) tag = "R8";
        wset = 0; wclr = 0;
        if (v && w && al && inrng) begin
            if (s) m_mem[wi[5:0]] = d;
            else if (wi == 0) wclr = d;
            else if (wi == 1) m_ctrl = d;
            else wset = d;
        end
        m_stat = (m_stat & ~wclr) | {24'h0, hs};
        m_cmd  = (m_cmd & ~hc) | wset;
        @(posedge clk);
        #5;
        check(irq == |(m_stat[7:0] & m_ctrl[7:0]), "R5", {31'h0, irq}, {31'h0, |(m_stat[7:0] & m_ctrl[7:0])});
        check(host_cmd == m_cmd, "R9", host_cmd, m_cmd);
        check(rsp_valid == ev, "R6", {31'h0, rsp_valid}, {31'h0, ev});
        if (ev) begin
            check(rsp_data == er, tag, rsp_data, er);
            if (!s) check(rsp_data[31:16] == 16'h0, "R6", rsp_data, er);
        end
    endtask

    task automatic idle();
        step(0, 0, 0, '0, 0, 0, 0);
    endtask

    initial begin
        #(20 * 150000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        for (int i = 0; i < RW; i++) m_mem[i] = 0;
        #15;
        // R1: reset state at the ports
        check(irq == 0 && host_cmd == 0 && rsp_valid == 0, "R1", host_cmd, 0);
        rst_n = 1;
        #20;
        check(irq == 0 && host_cmd == 0 && rsp_valid == 0, "R1", {31'h0, irq}, 0);
        step(1, 0, 0, 12'h000, 0, 0, 0);  // R1 status reads 0
        step(1, 0, 0, 12'h004, 0, 0, 0);  // R1 control reads 0
        step(1, 0, 0, 12'h008, 0, 0, 0);  // R1 command reads 0

        // R8: fill the RAM so that every word has a known value
        for (int i = 0; i < RW; i++) step(1, 1, 1, AW'(i * 4), 32'hC0DE_0000 ^ (i * 32'h0101_0033), 0, 0);
        step(1, 0, 1, 12'h0FC, 0, 0, 0);   // R8 last word
        step(1, 0, 1, 12'h100, 0, 0, 0);   // R8 beyond depth reads 0
        step(1, 1, 1, 12'h104, 32'hFFFF_FFFF, 0, 0); // R8 ignored write
        step(1, 0, 1, 12'h000, 0, 0, 0);

        // R2 / R6: truncated read of a full-width control value
        step(1, 1, 0, 12'h004, 32'hDEAD_BE01, 0, 0);
        step(1, 0, 0, 12'h004, 0, 0, 0);
        // R5: host set on an enabled channel raises irq one edge later
        idle();
        step(0, 0, 0, '0, 0, 8'h01, 0);
        idle();
        // R4: host set wins against a same-cycle local clear
        step(1, 1, 0, 12'h000, 32'h0000_0001, 8'h01, 0);
        step(1, 0, 0, 12'h000, 0, 0, 0);
        step(1, 1, 0, 12'h000, 32'h0000_0001, 0, 0);  // R5 irq falls
        // R5: enabling write on a pending status
        step(0, 0, 0, '0, 0, 8'h80, 0);
        step(1, 1, 0, 12'h004, 32'h0000_0080, 0, 0);
        // R3: local set wins over host clear, host clear acknowledges
        step(1, 1, 0, 12'h008, 32'h8001_00A5, 0, 0);
        step(1, 1, 0, 12'h008, 32'h0000_0080, 0, 32'h0000_00A0);
        step(1, 1, 0, 12'h008, 32'h0000_0000, 0, 0);
        step(1, 0, 0, 12'h008, 0, 0, 0);
        // R7: misaligned and unmapped accesses
        step(1, 1, 0, 12'h005, 32'h1234_5678, 0, 0);
        step(1, 1, 0, 12'h00C, 32'h1234_5678, 0, 0);
        step(1, 0, 0, 12'h004, 0, 0, 0);
        step(1, 0, 0, 12'h00C, 0, 0, 0);
        step(1, 0, 0, 12'h006, 0, 0, 0);
        step(1, 0, 1, 12'h002, 0, 0, 0);

        // Random mix
        for (int n = 0; n < 3000; n++) begin
            logic [AW-1:0] a;
            logic [31:0] d, hc;
            logic [7:0] hs;
            logic sp;
            int k;
            k = int'($urandom % 10);
            sp = (k >= 7);
            if (sp)          a = AW'(($urandom % 80) * 4);
            else if (k < 3)  a = AW'(k * 4);
            else if (k < 5)  a = AW'(k * 4 - 12);
            else if (k == 5) a = AW'(12 + ($urandom % 8) * 4);
            else             a = AW'(($urandom % 12) | 1);
            d  = $urandom;
            hs = ($urandom % 4 == 0) ? 8'($urandom) : 8'h0;
            hc = ($urandom % 5 == 0) ? $urandom : 32'h0;
            step(($urandom % 8) != 0, ($urandom % 2) == 0, sp, a, d, hs, hc);
        end
        idle();
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule